// File: doc/BRIEF.md
# Paged Host Register File with Interrupt Status

This block is the register file that a host processor sees on a network controller. A small synchronous bus reaches sixteen byte offsets. A two-bit page field in the command register turns those offsets into several register pages. Offset 0 is the command register on every page. On page 0, reading and writing the same offset often reach different registers. Writes hold configuration for the datapath, such as ring boundaries, transmit setup, DMA setup and the receive, transmit and data options. Reads return live values that the datapath supplies, such as the DMA address counters and the transmit and receive status bytes. Page 2 reads back the write-only configuration of page 0. Page 1 holds the station address, the current-page byte and the hash filter bytes.

The block also holds the interrupt status and mask registers and drives one interrupt line. Transmit, receive and DMA logic set the status bits with one-cycle event pulses. The host clears them by writing 1 to them. A read-only reset-state flag follows the stop and start commands. The transmit-request command bit is set by the host and cleared by the transmit logic when a frame finishes.

Top module: `netc_regfile`

## Requirements
- R1: The page is command bits 7:6 (00 page 0, 01 page 1, 10 page 2, 11 page 3). A write at offsets 1 to 15 changes only the register of the page selected at the time of the write.
- R2: Offset 0 reads and writes the command register on every page. After reset the command register is 0x01.
- R3: On page 0, reads return these values: offsets 1 and 2 give the local DMA address input (low byte, high byte); offsets 8 and 9 give the remote DMA address input (low, high); offset 4 gives the transmit status input; offset 12 gives the receive status input; offset 3 gives the boundary register. Writes at offsets 1 to 6 and 8 to 14 store configuration bytes, presented on `p0_cfg` at byte index equal to the offset. Offsets 5, 6, 10, 11, 13 and 14 read 0x00.
- R4: Command bit 0 is stop and bit 1 is start. Status read bit 7 is the reset-state flag. The flag is 1 after reset and after any command write with bit 0 set. It is cleared by a command write with bit 0 clear and bit 1 set.
- R5: Command bit 2 is the transmit request. A command write with bit 2 = 1 sets it, and a command write with bit 2 = 0 leaves it unchanged. A `tx_end` pulse clears it in the next cycle. A set in the same cycle as `tx_end` wins.
- R6: Status bits 0 to 6, read at page 0 offset 7, are set by `evt_set` pulses of the same bit. Each bit stays set until the host writes 1 to it at page 0 offset 7. Writing 0 has no effect, and a new event in the same cycle as the clear keeps the bit set.
- R7: The mask is written at page 0 offset 15 and read at page 2 offset 15, with bit 7 reading 0. `irq` is high exactly when some status bit 0 to 6 and its mask bit are both 1.
- R8: Page 3 offsets 1 to 15 and page 2 offsets 3, 5 to 11 read 0x00. Writes at offsets 1 to 15 on pages 2 and 3 change no register.
- R9: Read data appears on `bus_rdata` one cycle after the cycle in which `bus_rd` is high, and holds while `bus_rd` is low.
- R10: Page 1 offsets 1 to 15 are read/write bytes that read back the last value written. They are presented on `p1_cfg` at byte index equal to the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| ldma_addr | input | 16 | Local DMA address from datapath |
| rdma_addr | input | 16 | Remote DMA address from datapath |
| tx_stat | input | 8 | Transmit status byte |
| rx_stat | input | 8 | Receive status byte |
| evt_set | input | 7 | Event pulses, one per status bit 0 to 6 |
| tx_end | input | 1 | Transmission finished or aborted |
| cmd_q | output | 8 | Command register |
| p0_cfg | output | 128 | Page 0 configuration bytes, byte n is offset n |
| p1_cfg | output | 128 | Page 1 bytes, byte n is offset n |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted page field shows up in the first read that follows. It returns data from the wrong bank, or a page 3 zero where a value was expected, so one read of a known offset exposes it. An event bit that is lost, or a clear that fails, shows at the next read of offset 7. Where the mask enables the bit, it shows one cycle earlier on `irq`. A transmit request or reset flag that is not updated shows on `cmd_q`, or in status bit 7, in the cycle after the command write or the `tx_end` pulse.

// File: rtl/rf_pkg.sv
// Shared constants for the paged host register file.
// Assumes an 8-bit data bus and 16 offsets per page.
package rf_pkg;
    localparam int OFF_CMD   = 0;
    localparam int OFF_BNDRY = 3;
    localparam int OFF_ISR   = 7;
    localparam int OFF_IMR   = 15;

    localparam int BIT_STOP  = 0;
    localparam int BIT_START = 1;
    localparam int BIT_TXREQ = 2;

    typedef enum logic [1:0] {
        PG0 = 2'd0,
        PG1 = 2'd1,
        PG2 = 2'd2,
        PG3 = 2'd3
    } page_t;
endpackage

// File: rtl/rf_bank.sv
// Bank of byte registers indexed by offset. Only the offsets set in WMASK
// get storage; the other bytes read as zero. Assumes wr_en lasts one cycle per write.
module rf_bank #(
    parameter int N = 16,
    parameter int DW = 8,
    parameter logic [N-1:0] WMASK = '1,
    localparam int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    output logic [N*DW-1:0] q_flat
);
    for (genvar i = 0; i < N; i++) begin : g_byte
        if (WMASK[i]) begin : g_reg
            // Hold one configuration byte; loaded when its offset is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_flat[i*DW +: DW] <= '0;
                else if (wr_en && (int'(waddr) == i))
                    q_flat[i*DW +: DW] <= wdata;
            end
        end else begin : g_zero
            assign q_flat[i*DW +: DW] = '0;
        end
    end
endmodule

// File: rtl/rf_cmd.sv
// Command register plus the read-only reset-state flag.
// The transmit-request bit is set only by the host and cleared by tx_end.
// Assumes wr_cmd is already qualified with offset 0.
module rf_cmd #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wdata,
    input  logic          tx_end,
    output logic [DW-1:0] cmd_q,
    output logic          rst_st
);
    import rf_pkg::*;
    localparam logic [DW-1:0] CMD_RESET = DW'(1) << BIT_STOP;

    logic txreq_n;

    // Next value of the transmit request: kept until tx_end, set by a write of 1.
    always_comb begin
        txreq_n = (cmd_q[BIT_TXREQ] && !tx_end) || (wr_cmd && wdata[BIT_TXREQ]);
    end

    // Command register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_RESET;
        end else begin
            if (wr_cmd)
                cmd_q <= wdata;
            cmd_q[BIT_TXREQ] <= txreq_n;
        end
    end

    // Reset-state flag: set by stop, cleared by start without stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_st <= 1'b1;
        else if (wr_cmd && wdata[BIT_STOP])
            rst_st <= 1'b1;
        else if (wr_cmd && wdata[BIT_START])
            rst_st <= 1'b0;
    end

    p_txreq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && !(wr_cmd && wdata[BIT_TXREQ])) |=> !cmd_q[BIT_TXREQ]);
    p_txreq_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[BIT_TXREQ] && !tx_end) |=> cmd_q[BIT_TXREQ]);
    p_rst_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[BIT_STOP]) |=> rst_st);
    p_rst_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[BIT_START] && !wdata[BIT_STOP]) |=> !rst_st);
endmodule

// File: rtl/rf_irq.sv
// Interrupt status (set by events, cleared by writing 1) and mask, with
// one interrupt line. Assumes event pulses last one cycle per occurrence.
module rf_irq #(
    parameter int NEVT = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt_set,
    input  logic            clr_wr,
    input  logic            imr_wr,
    input  logic [NEVT-1:0] wdata,
    output logic [NEVT-1:0] isr,
    output logic [NEVT-1:0] imr,
    output logic            irq
);
    // Status bits: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr <= '0;
        else
            isr <= (isr & ~(clr_wr ? wdata : '0)) | evt_set;
    end

    // Mask register, one enable per status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            imr <= '0;
        else if (imr_wr)
            imr <= wdata;
    end

    assign irq = |(isr & imr);

    p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr & $past(evt_set)) == $past(evt_set)));
    p_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((isr & $past(isr)) == $past(isr)));
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt_set) || $past(imr_wr)));
endmodule

// File: rtl/netc_regfile.sv
// Host-facing paged register file of a network controller.
// Decodes the 4-bit offset against the page held in command bits 7:6,
// routes writes to the command, status/mask and bank registers, and
// registers read data. Assumes bus_wr lasts one cycle per write. A read has no
// side effect.
module netc_regfile #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int NREG = 1 << AW,
    localparam int NEVT = DW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [2*DW-1:0]   ldma_addr,
    input  logic [2*DW-1:0]   rdma_addr,
    input  logic [DW-1:0]     tx_stat,
    input  logic [DW-1:0]     rx_stat,
    input  logic [NEVT-1:0]   evt_set,
    input  logic              tx_end,
    output logic [DW-1:0]     cmd_q,
    output logic [NREG*DW-1:0] p0_cfg,
    output logic [NREG*DW-1:0] p1_cfg,
    output logic              irq
);
    import rf_pkg::*;

    localparam logic [NREG-1:0] P0_WMASK =
        ~((NREG'(1) << OFF_CMD) | (NREG'(1) << OFF_ISR) | (NREG'(1) << OFF_IMR));
    localparam logic [NREG-1:0] P1_WMASK = ~(NREG'(1) << OFF_CMD);
    localparam logic [NREG-1:0] P2_RMASK =
        (NREG'(1) << 1) | (NREG'(1) << 2) | (NREG'(1) << 4) |
        (NREG'(1) << 12) | (NREG'(1) << 13) | (NREG'(1) << 14);

    page_t           page;
    logic            wr_cmd, wr_p0, wr_p1;
    logic            rst_st;
    logic [NEVT-1:0] isr, imr;
    logic [DW-1:0]   rd_mux;
    int              idx;

    assign page   = page_t'(cmd_q[DW-1 -: 2]);
    assign wr_cmd = bus_wr && (int'(bus_addr) == OFF_CMD);
    assign wr_p0  = bus_wr && !wr_cmd && (page == PG0);
    assign wr_p1  = bus_wr && !wr_cmd && (page == PG1);
    assign idx    = int'(bus_addr);

    rf_cmd #(.DW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(bus_wdata),
        .tx_end(tx_end), .cmd_q(cmd_q), .rst_st(rst_st)
    );

    rf_irq #(.NEVT(NEVT)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .clr_wr(wr_p0 && (idx == OFF_ISR)),
        .imr_wr(wr_p0 && (idx == OFF_IMR)),
        .wdata(bus_wdata[NEVT-1:0]), .isr(isr), .imr(imr), .irq(irq)
    );

    rf_bank #(.N(NREG), .DW(DW), .WMASK(P0_WMASK)) u_bank0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_p0), .waddr(bus_addr),
        .wdata(bus_wdata), .q_flat(p0_cfg)
    );

    rf_bank #(.N(NREG), .DW(DW), .WMASK(P1_WMASK)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_p1), .waddr(bus_addr),
        .wdata(bus_wdata), .q_flat(p1_cfg)
    );

    // Read decode: command everywhere, then page-specific sources.
    always_comb begin
        rd_mux = '0;
        if (idx == OFF_CMD) begin
            rd_mux = cmd_q;
        end else begin
            unique case (page)
                PG0: begin
                    case (idx)
                        1:         rd_mux = ldma_addr[DW-1:0];
                        2:         rd_mux = ldma_addr[2*DW-1:DW];
                        OFF_BNDRY: rd_mux = p0_cfg[OFF_BNDRY*DW +: DW];
                        4:         rd_mux = tx_stat;
                        OFF_ISR:   rd_mux = {rst_st, isr};
                        8:         rd_mux = rdma_addr[DW-1:0];
                        9:         rd_mux = rdma_addr[2*DW-1:DW];
                        12:        rd_mux = rx_stat;
                        default:   rd_mux = '0;
                    endcase
                end
                PG1: rd_mux = p1_cfg[idx*DW +: DW];
                PG2: begin
                    if (idx == OFF_IMR)
                        rd_mux = {1'b0, imr};
                    else if (P2_RMASK[idx])
                        rd_mux = p0_cfg[idx*DW +: DW];
                end
                PG3: rd_mux = '0;
            endcase
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    p_page3_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (page == PG3) && (idx != OFF_CMD)) |=> (bus_rdata == '0));
    p_page_isolate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (page != PG0)) |=> $stable(p0_cfg));
    p_bank1_isolate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (page != PG1)) |=> $stable(p1_cfg));
endmodule

// File: tb/test_netc_regfile.sv
module test_netc_regfile;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [3:0]   bus_addr = 0;
    logic [7:0]   bus_wdata = 0;
    logic         bus_wr = 0, bus_rd = 0;
    logic [7:0]   bus_rdata;
    logic [15:0]  ldma_addr = 16'h1234, rdma_addr = 16'h5678;
    logic [7:0]   tx_stat = 8'h9A, rx_stat = 8'hBC;
    logic [6:0]   evt_set = 0;
    logic         tx_end = 0;
    logic [7:0]   cmd_q;
    logic [127:0] p0_cfg, p1_cfg;
    logic         irq;

    int n_chk = 0, n_fail = 0;
    bit run = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    netc_regfile i_netc_regfile (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ldma_addr(ldma_addr), .rdma_addr(rdma_addr), .tx_stat(tx_stat),
        .rx_stat(rx_stat), .evt_set(evt_set), .tx_end(tx_end), .cmd_q(cmd_q),
        .p0_cfg(p0_cfg), .p1_cfg(p1_cfg), .irq(irq)
    );

    // Behavioural reference model.
    logic [7:0] m_cmd, m_rdata, m_p0 [16], m_p1 [16];
    logic [6:0] m_isr, m_imr;
    logic       m_rst;

    function automatic logic [7:0] model_read(logic [1:0] pg, int a);
        if (a == 0) return m_cmd;
        case (pg)
            2'd0: case (a)
                1: return ldma_addr[7:0];
                2: return ldma_addr[15:8];
                3: return m_p0[3];
                4: return tx_stat;
                7: return {m_rst, m_isr};
                8: return rdma_addr[7:0];
                9: return rdma_addr[15:8];
                12: return rx_stat;
                default: return 8'h00;
            endcase
            2'd1: return m_p1[a];
            2'd2: begin
                if (a == 15) return {1'b0, m_imr};
                if (a == 1 || a == 2 || a == 4 || a == 12 || a == 13 || a == 14)
                    return m_p0[a];
                return 8'h00;
            end
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 8'h01; m_rst = 1; m_isr = 0; m_imr = 0; m_rdata = 0;
            for (int i = 0; i < 16; i++) begin m_p0[i] = 0; m_p1[i] = 0; end
        end else begin
            logic [1:0] pg;
            int a;
            logic tq;
            pg = m_cmd[7:6];
            a = int'(bus_addr);
            if (bus_rd) m_rdata = model_read(pg, a);
            if (bus_wr && pg == 0 && a == 7) m_isr = m_isr & ~bus_wdata[6:0];
            m_isr = m_isr | evt_set;
            if (bus_wr && pg == 0 && a == 15) m_imr = bus_wdata[6:0];
            if (bus_wr && pg == 0 && a != 0 && a != 7 && a != 15) m_p0[a] = bus_wdata;
            if (bus_wr && pg == 1 && a != 0) m_p1[a] = bus_wdata;
            tq = (m_cmd[2] && !tx_end) || (bus_wr && a == 0 && bus_wdata[2]);
            if (bus_wr && a == 0) begin
                m_cmd = bus_wdata;
                if (bus_wdata[0]) m_rst = 1;
                else if (bus_wdata[1]) m_rst = 0;
            end
            m_cmd[2] = tq;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the model.
    always @(negedge clk) begin
        if (run) begin
            chk("R9", bus_rdata, m_rdata);
            chk("R2", cmd_q, m_cmd);
            chk("R7", {7'd0, irq}, {7'd0, |(m_isr & m_imr)});
        end
    end

    task automatic cyc(bit w, bit r, logic [3:0] a, logic [7:0] d, logic [6:0] e, bit te);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt_set = e; tx_end = te;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; evt_set = 0; tx_end = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        cyc(1, 0, a, d, 0, 0);
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] q);
        cyc(0, 1, a, 0, 0, 0);
        q = bus_rdata;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        run = 1;
        chk("R2 reset cmd", cmd_q, 8'h01);
        rd(0, v); chk("R2 cmd read", v, 8'h01);
        rd(7, v); chk("R4 reset flag", v, 8'h80);
        rd(8, v); chk("R3 rdma lo", v, 8'h78);
        rd(12, v); chk("R3 rx stat", v, 8'hBC);
        rd(4, v); chk("R3 tx stat", v, 8'h9A);
        wr(0, 8'h02);
        rd(7, v); chk("R4 start clears flag", v, 8'h00);
        wr(1, 8'h46);
        rd(1, v); chk("R3 split read", v, 8'h34);
        wr(10, 8'h55);
        rd(10, v); chk("R3 write-only", v, 8'h00);
        wr(0, 8'h82);
        rd(1, v); chk("R3 readback page2", v, 8'h46);
        rd(0, v); chk("R2 cmd on page2", v, 8'h82);
        wr(1, 8'h99);
        rd(1, v); chk("R8 page2 write ignored", v, 8'h46);
        rd(6, v); chk("R8 page2 reserved", v, 8'h00);
        wr(0, 8'h42);
        wr(5, 8'hA5); wr(8, 8'h3C);
        rd(5, v); chk("R10 bank1", v, 8'hA5);
        rd(8, v); chk("R10 bank1", v, 8'h3C);
        chk("R10 p1_cfg", p1_cfg[8*8 +: 8], 8'h3C);
        wr(0, 8'h02);
        rd(5, v); chk("R1 page0 view", v, 8'h00);
        wr(5, 8'h77);
        chk("R1 p0_cfg", p0_cfg[5*8 +: 8], 8'h77);
        wr(0, 8'h42);
        rd(5, v); chk("R1 page1 untouched", v, 8'hA5);
        wr(0, 8'hC2);
        wr(3, 8'hFF);
        rd(3, v); chk("R8 page3 read", v, 8'h00);
        wr(0, 8'h42);
        rd(3, v); chk("R8 page3 write ignored p1", v, 8'h00);
        wr(0, 8'h02);
        rd(3, v); chk("R8 page3 write ignored p0", v, 8'h00);
        wr(0, 8'h06); chk("R5 txreq set", cmd_q, 8'h06);
        wr(0, 8'h02); chk("R5 write 0 keeps", cmd_q, 8'h06);
        cyc(0, 0, 0, 0, 0, 1); chk("R5 tx_end clears", cmd_q, 8'h02);
        cyc(1, 0, 0, 8'h06, 0, 1); chk("R5 set wins", cmd_q, 8'h06);
        cyc(0, 0, 0, 0, 0, 1);
        wr(15, 8'h85);
        wr(0, 8'h82);
        rd(15, v); chk("R7 mask readback", v, 8'h05);
        wr(0, 8'h02);
        cyc(0, 0, 0, 0, 7'h02, 0); chk("R7 masked", {7'd0, irq}, 8'h00);
        rd(7, v); chk("R6 event set", v, 8'h02);
        cyc(0, 0, 0, 0, 7'h01, 0); chk("R7 irq high", {7'd0, irq}, 8'h01);
        wr(7, 8'h00);
        rd(7, v); chk("R6 write 0 no effect", v, 8'h03);
        wr(7, 8'h01);
        rd(7, v); chk("R6 w1c", v, 8'h02);
        chk("R7 irq low", {7'd0, irq}, 8'h00);
        cyc(1, 0, 7, 8'h02, 7'h02, 0);
        rd(7, v); chk("R6 event wins", v, 8'h02);
        wr(0, 8'h03);
        rd(7, v); chk("R4 stop sets flag", v, 8'h82);
        wr(0, 8'h02);
        rd(7, v); chk("R4 start clears", v, 8'h02);
        rd(1, v);
        repeat (3) @(negedge clk);
        chk("R9 hold", bus_rdata, 8'h34);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule